// File: doc/BRIEF.md
# Four-Bit Adder-Subtractor with Magnitude Flags

This combinational unit takes two unsigned operands and a mode bit. With the mode bit low it adds the operands. With the mode bit high it subtracts the second operand from the first. It subtracts by two's-complement addition on the same ripple chain of full-adder cells that it uses for adding. Each bit of the second operand goes through an XOR gated by the mode bit, and the mode bit also drives the carry into the lowest cell. The outputs are the result word and the final carry.

A small decode stage turns the subtraction result and final carry into three magnitude flags: equal, less-than and greater-than. The flags need no separate comparator. Equal comes from an all-zero result, less-than from the inverted carry (the borrow), and greater-than from the absence of both. In add mode the flags are held low. The operand width is a parameter and defaults to 4.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_i`=0, `{cout_o, res_o}` equals `opa_i + opb_i` as a 5-bit unsigned sum.
- R2: With `sub_i`=1, `res_o` equals `(opa_i - opb_i) mod 16`.
- R3: With `sub_i`=1, `cout_o` is 1 exactly when `opa_i >= opb_i`, which means it is the inverse of a true borrow.
- R4: With `sub_i`=0, `cout_o` is 1 exactly when the unsigned sum exceeds 15.
- R5: `eq_o` is 1 exactly when `sub_i`=1 and `opa_i == opb_i`.
- R6: `lt_o` is 1 exactly when `sub_i`=1 and `opa_i < opb_i`.
- R7: `gt_o` is 1 exactly when `sub_i`=1 and `opa_i > opb_i`.
- R8: With `sub_i`=0, all three flags are 0 for every operand pair.
- R9: With `sub_i`=1, exactly one of the three flags is 1 for every operand pair.
- R10: Equal operands in subtract mode give `res_o`=0000 and `cout_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | First unsigned operand (minuend when subtracting) |
| opb_i | input | WIDTH | Second unsigned operand (subtrahend when subtracting) |
| sub_i | input | 1 | Mode: 0 adds, 1 subtracts |
| res_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry out of the top cell |
| eq_o | output | 1 | Operands equal (subtract mode only) |
| lt_o | output | 1 | First operand below second (subtract mode only) |
| gt_o | output | 1 | First operand above second (subtract mode only) |

## Verification
Two functions can act in the same evaluation. One is the arithmetic result with its carry. The other is the flag decode, which reads that same result and carry. A wrong carry therefore corrupts the carry output and the less-than and greater-than flags at once. The bench provokes this with boundary pairs such as 0−15, 15−0 and equal operands, and it also sweeps all 256 operand pairs in both modes. Each output is judged on its own against a reference computed from plain integer arithmetic. This keeps a carry fault from hiding behind a correct-looking flag.

// File: rtl/addsub_cmp_pkg.sv
package addsub_cmp_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } mag_flags_t;

    localparam mag_flags_t FLAGS_NONE = '{gt: 1'b0, lt: 1'b0, eq: 1'b0};

    function automatic logic cell_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic cell_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (ci & (x ^ y));
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import addsub_cmp_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = cell_sum(x_i, y_i, c_i);
    assign c_o = cell_carry(x_i, y_i, c_i);
endmodule

// File: rtl/operand_cond.sv
module operand_cond #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] raw_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] cond_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_xor
        assign cond_o[k] = raw_i[k] ^ inv_i;
    end

    always_comb begin
        p_cond_polarity_r2: assert (inv_i ? (cond_o == ~raw_i) : (cond_o == raw_i))
            else $error("operand conditioner polarity wrong");
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        fa_cell u_cell (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .c_i (carry[k]),
            .s_o (sum_o[k]),
            .c_o (carry[k+1])
        );
    end

    assign cout_o = carry[WIDTH];

    always_comb begin
        p_chain_total_r4: assert ({cout_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i}))
            else $error("ripple chain total wrong");
    end
endmodule

// File: rtl/flag_decode.sv
module flag_decode
    import addsub_cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] diff_i,
    input  logic             carry_i,
    input  op_mode_e         mode_i,
    output mag_flags_t       flags_o
);
    logic zero;
    logic borrow;
    logic active;

    assign zero   = ~|diff_i;
    assign borrow = ~carry_i;
    assign active = (mode_i == MODE_SUB);

    always_comb begin
        flags_o = FLAGS_NONE;
        if (active) begin
            flags_o.eq = zero;
            flags_o.lt = borrow;
            flags_o.gt = ~(zero | borrow);
        end
    end

    always_comb begin
        p_add_quiet_r8: assert (active || flags_o == FLAGS_NONE)
            else $error("flags raised in add mode");
        p_one_flag_r9: assert (!active || $countones(flags_o) == 1)
            else $error("flag count not one in subtract mode");
        p_eq_zero_r5: assert (!flags_o.eq || diff_i == '0)
            else $error("equal flag with nonzero difference");
    end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
    import addsub_cmp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             eq_o,
    output logic             lt_o,
    output logic             gt_o
);
    localparam int EXT = WIDTH + 1;

    op_mode_e         mode;
    logic [WIDTH-1:0] opb_cond;
    mag_flags_t       flags;

    assign mode = op_mode_e'(sub_i);

    operand_cond #(.WIDTH(WIDTH)) u_cond (
        .raw_i  (opb_i),
        .inv_i  (sub_i),
        .cond_o (opb_cond)
    );

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .x_i    (opa_i),
        .y_i    (opb_cond),
        .cin_i  (sub_i),
        .sum_o  (res_o),
        .cout_o (cout_o)
    );

    flag_decode #(.WIDTH(WIDTH)) u_flags (
        .diff_i  (res_o),
        .carry_i (cout_o),
        .mode_i  (mode),
        .flags_o (flags)
    );

    assign eq_o = flags.eq;
    assign lt_o = flags.lt;
    assign gt_o = flags.gt;

    always_comb begin
        p_add_sum_r1: assert (sub_i || {cout_o, res_o} == (EXT'(opa_i) + EXT'(opb_i)))
            else $error("add result wrong");
        p_sub_diff_r2: assert (!sub_i || res_o == WIDTH'(opa_i - opb_i))
            else $error("subtract result wrong");
        p_sub_carry_r3: assert (!sub_i || cout_o == (opa_i >= opb_i))
            else $error("subtract carry wrong");
        p_lt_order_r6: assert (!lt_o || opa_i < opb_i)
            else $error("less-than flag wrong");
        p_gt_order_r7: assert (!gt_o || opa_i > opb_i)
            else $error("greater-than flag wrong");
        p_equal_case_r10: assert (!(sub_i && opa_i == opb_i) || (res_o == '0 && cout_o))
            else $error("equal operands gave wrong outputs");
    end
endmodule

// File: tb/sim_addsub_cmp.sv
module sim_addsub_cmp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a, b;
    logic       m;
    logic [3:0] s;
    logic       c, eq, lt, gt;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2 clk = ~clk;

    addsub_cmp #(.WIDTH(4)) u0 (
        .opa_i(a), .opb_i(b), .sub_i(m),
        .res_o(s), .cout_o(c), .eq_o(eq), .lt_o(lt), .gt_o(gt)
    );

    // vector: {mode, a, b, expected s, expected carry, expected {gt,lt,eq}}
    localparam logic [16:0] VEC [10] = '{
        {1'b0, 4'd3,  4'd4,  4'd7,  1'b0, 3'b000},
        {1'b0, 4'd9,  4'd8,  4'd1,  1'b1, 3'b000},
        {1'b0, 4'd15, 4'd15, 4'd14, 1'b1, 3'b000},
        {1'b0, 4'd0,  4'd0,  4'd0,  1'b0, 3'b000},
        {1'b1, 4'd5,  4'd5,  4'd0,  1'b1, 3'b001},
        {1'b1, 4'd3,  4'd9,  4'd10, 1'b0, 3'b010},
        {1'b1, 4'd12, 4'd4,  4'd8,  1'b1, 3'b100},
        {1'b1, 4'd0,  4'd15, 4'd1,  1'b0, 3'b010},
        {1'b1, 4'd15, 4'd0,  4'd15, 1'b1, 3'b100},
        {1'b1, 4'd0,  4'd0,  4'd0,  1'b1, 3'b001}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: a=%0d b=%0d m=%0d actual=%0d expected=%0d", tag, a, b, m, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; m = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state: add of zeros, flags quiet (R1, R8)
        check("R1 idle result", {c, s}, 0);
        check("R8 idle flags", {gt, lt, eq}, 0);

        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            {m, a, b} = VEC[i][16:8];
            @(negedge clk);
            check(m ? "R2 table result" : "R1 table result", s, VEC[i][7:4]);
            check(m ? "R3 table carry" : "R4 table carry", c, VEC[i][3]);
            check("R5/R6/R7 table flags", {gt, lt, eq}, VEC[i][2:0]);
        end

        // equal-operand corner (R10)
        @(posedge clk);
        m = 1'b1; a = 4'd9; b = 4'd9;
        @(negedge clk);
        check("R10 equal result", s, 0);
        check("R10 equal carry", c, 1);

        // exhaustive sweep against integer reference
        for (int mi = 0; mi < 2; mi++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    int full;
                    @(posedge clk);
                    m = mi[0]; a = ai[3:0]; b = bi[3:0];
                    full = (mi == 1) ? (ai + 16 - bi) : (ai + bi);
                    @(negedge clk);
                    if (mi == 0) begin
                        check("R1 sum", {c, s}, ai + bi);
                        check("R4 carry", c, (ai + bi > 15) ? 1 : 0);
                        check("R8 flags", {gt, lt, eq}, 0);
                    end else begin
                        check("R2 diff", s, full % 16);
                        check("R3 carry", c, (ai >= bi) ? 1 : 0);
                        check("R5 eq", eq, (ai == bi) ? 1 : 0);
                        check("R6 lt", lt, (ai < bi) ? 1 : 0);
                        check("R7 gt", gt, (ai > bi) ? 1 : 0);
                        check("R9 one flag", int'(eq) + int'(lt) + int'(gt), 1);
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule